// File: doc/BRIEF.md
# Memory-Driven Video Scanout with Stored Sync

This block produces a VGA-style raster stream without any porch or sync comparators. A free-running binary counter steps through a dual-port frame memory, fetching one 8-bit word per pixel clock. Each word carries a 6-bit colour and the horizontal and vertical sync levels. The pins reproduce exactly what is stored, so the software that fills the memory decides where the sync pulses sit and which polarity they have.

A host port writes words at any time. The video port keeps fetching with no arbitration and no stall. The frame is `LINE_TICKS * FRAME_LINES` words. The full-size configuration is 264 ticks per line and 628 lines, which gives 165792 words and an 18-bit address. The defaults are smaller so that the memory stays small in elaboration.

Top module: `memscan_video`

## Requirements
- R1: Word bit layout: red is bits [1:0], green is bits [3:2], blue is bits [5:4], hSync is bit 6 and vSync is bit 7. Each output pin carries its field from the fetched word.
- R2: Out of reset, the video address advances by exactly one on every clock. It walks the frame linearly.
- R3: The video address never reaches `FRAME_WORDS` (`LINE_TICKS * FRAME_LINES`). After `FRAME_WORDS-1` it returns to 0.
- R4: A word fetched while the counter holds address A appears on the pins two clocks later. Colour and sync bits of that word appear in the same cycle.
- R5: Sync pins come only from the stored bits. Any placement and polarity in memory, for example active-low hSync with active-high vSync, is reproduced unchanged.
- R6: The host write is taken on a rising edge with `hostWe` high, in any cycle while scanning continues. It shows on the pins when the scan next reaches that address.
- R7: When a host write and a video fetch hit the same address on the same edge, the fetch returns the old word. The new word shows one frame later.
- R8: A host write to an address of `FRAME_WORDS` or above changes no memory word.
- R9: Synchronous reset sets the counter to 0 and drives all pins low. The pins stay low for the first clock after release. The word at address 0 appears after the second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWe | input | 1 | Host write enable |
| hostAddr | input | ADDR_W | Host write address |
| hostData | input | 8 | Host write word (layout per R1) |
| pixRed | output | 2 | Registered red level |
| pixGreen | output | 2 | Registered green level |
| pixBlue | output | 2 | Registered blue level |
| hSync | output | 1 | Registered horizontal sync level |
| vSync | output | 1 | Registered vertical sync level |

## Verification
The scan is first run over an address-derived fill, where every word differs from its neighbours. This exposes any skipped, repeated or misaligned address as well as a wrong latency. A line-structured fill with active-low horizontal and active-high vertical pulses shows that the sync pins follow memory alone. Host traffic is then mixed into the scan:
- random writes during scanning;
- a write aimed at the very word being fetched, which separates read-before-write from write-first behaviour;
- writes above the frame, which would reveal any address aliasing.

A reset in the middle of a frame checks the restart and the two-clock zero window.

// File: rtl/memscan_pkg.sv
package memscan_pkg;

  localparam int WORD_W = 8;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic clear;   // force output register to zero
    logic fetch;   // capture memory word at the video address
    logic load;    // move captured word to the output register
  } scanStrobe_t;

endpackage

// File: rtl/memscan_ctrl.sv
module memscan_ctrl
  import memscan_pkg::*;
#(
  parameter int FRAME_WORDS = 240,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] vidAddr,
  output scanStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_WORDS - 1);

  logic primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      vidAddr <= '0;
      primed  <= 1'b0;
    end else begin
      vidAddr <= (vidAddr == LAST_ADDR) ? '0 : vidAddr + 1'b1;
      primed  <= 1'b1;
    end
  end

  always_comb begin
    strobe.clear = rst;
    strobe.fetch = !rst;
    strobe.load  = primed && !rst;
  end

endmodule

// File: rtl/memscan_datapath.sv
module memscan_datapath
  import memscan_pkg::*;
#(
  parameter int FRAME_WORDS = 240,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  scanStrobe_t       strobe,
  input  logic [ADDR_W-1:0] vidAddr,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostData,
  output logic [WORD_W-1:0] outWord
);

  localparam logic [ADDR_W:0] WORDS_EXT = (ADDR_W + 1)'(FRAME_WORDS);

  logic [WORD_W-1:0] frameMem [FRAME_WORDS];
  logic [WORD_W-1:0] fetchQ;
  logic              hostHit;

  assign hostHit = hostWe && ({1'b0, hostAddr} < WORDS_EXT);

  // host port
  always_ff @(posedge clk) begin
    if (hostHit) frameMem[hostAddr] <= hostData;
  end

  // video port: nonblocking read sees the pre-write word on a collision
  always_ff @(posedge clk) begin
    if (strobe.fetch) fetchQ <= frameMem[vidAddr];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     outWord <= '0;
    else if (strobe.load) outWord <= fetchQ;
  end

endmodule

// File: rtl/memscan_video.sv
module memscan_video
  import memscan_pkg::*;
#(
  parameter int LINE_TICKS  = 24,
  parameter int FRAME_LINES = 10
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        hostWe,
  input  logic [$clog2(LINE_TICKS*FRAME_LINES)-1:0]   hostAddr,
  input  logic [7:0]                                  hostData,
  output logic [1:0]                                  pixRed,
  output logic [1:0]                                  pixGreen,
  output logic [1:0]                                  pixBlue,
  output logic                                        hSync,
  output logic                                        vSync
);

  localparam int FRAME_WORDS = LINE_TICKS * FRAME_LINES;
  localparam int ADDR_W      = $clog2(FRAME_WORDS);

  logic [ADDR_W-1:0] vidAddr;
  scanStrobe_t       strobe;
  logic [WORD_W-1:0] outWord;

  memscan_ctrl #(.FRAME_WORDS(FRAME_WORDS), .ADDR_W(ADDR_W)) ctrl (
    .clk    (clk),
    .rst    (rst),
    .vidAddr(vidAddr),
    .strobe (strobe)
  );

  memscan_datapath #(.FRAME_WORDS(FRAME_WORDS), .ADDR_W(ADDR_W)) dpath (
    .clk     (clk),
    .strobe  (strobe),
    .vidAddr (vidAddr),
    .hostWe  (hostWe),
    .hostAddr(hostAddr),
    .hostData(hostData),
    .outWord (outWord)
  );

  assign pixRed   = outWord[1:0];
  assign pixGreen = outWord[3:2];
  assign pixBlue  = outWord[5:4];
  assign hSync    = outWord[6];
  assign vSync    = outWord[7];

endmodule

// File: rtl/memscan_checker.sv
module memscan_checker #(
  parameter int FRAME_WORDS = 240,
  parameter int ADDR_W      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] vidAddr,
  input logic [7:0]        pixWord
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_WORDS - 1);

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
    {1'b0, vidAddr} < (ADDR_W + 1)'(FRAME_WORDS));

  assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    vidAddr == LAST_ADDR |=> vidAddr == '0);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    vidAddr != LAST_ADDR |=> vidAddr == $past(vidAddr) + 1'b1);

  assert_reset_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pixWord == 8'h00);

endmodule

bind memscan_video memscan_checker #(.FRAME_WORDS(FRAME_WORDS), .ADDR_W(ADDR_W)) chk (
  .clk    (clk),
  .rst    (rst),
  .vidAddr(vidAddr),
  .pixWord({vSync, hSync, pixBlue, pixGreen, pixRed})
);

// File: tb/tb_memscan_video.sv
module tb_memscan_video;

  localparam int LT = 24;
  localparam int FL = 10;
  localparam int N  = LT * FL;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0]    hostData = '0;
  logic [1:0]    pixRed, pixGreen, pixBlue;
  logic          hSync, vSync;

  int    checks = 0;
  int    failures = 0;
  bit    cmpOn = 1'b0;
  string phaseTag = "R2";

  always #10 clk = ~clk;

  memscan_video #(.LINE_TICKS(LT), .FRAME_LINES(FL)) dut (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue), .hSync(hSync), .vSync(vSync)
  );

  // behavioural reference: memory, address, one fetch stage, output
  logic [7:0] mMem [N];
  int         mAddr = 0;
  logic [7:0] mS1 = '0;
  bit         mS1v = 1'b0;
  logic [7:0] mOut = '0;

  always @(posedge clk) begin
    if (rst) begin
      mAddr = 0; mS1v = 1'b0; mOut = 8'h00;
    end else begin
      if (mS1v) mOut = mS1;
      mS1  = mMem[mAddr];
      mS1v = 1'b1;
      mAddr = (mAddr + 1) % N;
    end
    if (hostWe && int'(hostAddr) < N) mMem[hostAddr] = hostData;
  end

  function automatic logic [7:0] pinWord();
    return {vSync, hSync, pixBlue, pixGreen, pixRed};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmpOn) check(phaseTag, pinWord(), mOut);

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] syncPattern(int a);
    int x = a % LT;
    int y = a / LT;
    logic hs = !(x >= LT - 4 && x < LT - 2);   // active low
    logic vs = (y >= FL - 2);                  // active high
    return {vs, hs, 6'(a * 5 + 1)};
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic releaseAndCheck(logic [7:0] word0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R9", pinWord(), 8'h00);
    @(negedge clk);
    check("R4", pinWord(), word0);
    check("R1", {6'b0, pixRed},   {6'b0, word0[1:0]});
    check("R1", {6'b0, pixGreen}, {6'b0, word0[3:2]});
    check("R1", {6'b0, pixBlue},  {6'b0, word0[5:4]});
    check("R1", {6'b0, vSync, hSync}, {6'b0, word0[7:6]});
  endtask

  initial begin
    // fill during reset with an address-derived pattern
    rst = 1'b1;
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = AW'(a); hostData = 8'(a * 7 + 3);
    end
    @(negedge clk) hostWe = 1'b0;
    idle(2);
    check("R9", pinWord(), 8'h00);
    cmpOn = 1'b1;
    releaseAndCheck(8'h03);
    phaseTag = "R2"; idle(N);
    phaseTag = "R3"; idle(N + 5);

    // R5/R6: rewrite with a sync pattern while scanning
    phaseTag = "R6";
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = AW'(a); hostData = syncPattern(a);
    end
    @(negedge clk) hostWe = 1'b0;
    phaseTag = "R5"; idle(2 * N);

    // R7: write the word the next edge fetches
    begin
      logic [7:0] oldWord;
      @(negedge clk);
      oldWord  = mMem[mAddr];
      hostWe   = 1'b1; hostAddr = AW'(mAddr); hostData = ~oldWord;
      @(negedge clk) hostWe = 1'b0;
      @(negedge clk);
      check("R7", pinWord(), oldWord);
      phaseTag = "R7"; idle(N + 2);
    end

    // R8: writes above the frame must not land anywhere
    phaseTag = "R8";
    for (int a = N; a < (1 << AW); a++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = AW'(a); hostData = 8'hA5 ^ 8'(a);
    end
    @(negedge clk) hostWe = 1'b0;
    idle(N + 2);

    // R6: random traffic during scanning
    phaseTag = "R6";
    for (int i = 0; i < 2 * N; i++) begin
      @(negedge clk);
      hostWe = ($urandom_range(0, 2) == 0);
      hostAddr = AW'($urandom_range(0, N - 1));
      hostData = 8'($urandom);
    end
    @(negedge clk) hostWe = 1'b0;
    idle(N + 2);

    // R9: reset mid-frame
    phaseTag = "R9";
    @(negedge clk) rst = 1'b1;
    idle(3);
    check("R9", pinWord(), 8'h00);
    releaseAndCheck(mMem[0]);
    phaseTag = "R2"; idle(N);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule